// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block collects up to 32 peripheral interrupt sources and presents them to a parent interrupt controller as one request line. Software sees a small register window on a plain 32-bit read/write bus. It can read which sources are pending, read the current enable state, and disable or enable sources one bit at a time. Disabling and enabling go through two separate write-one registers, so no read-modify-write is needed and two agents cannot overwrite each other's mask changes.

A build-time parameter picks one of two behaviours. In the latched variant, a rising edge on a source is remembered in a pending bit until software acknowledges it by writing a one. In the level variant, the pending view is simply the live source inputs, and the acknowledge register does not exist. The parent request is registered and is raised whenever some pending source is enabled.

A handler normally reads the pending and enable views and services each enabled pending bit. For each one it disables the source and then acknowledges it, and it re-enables the source once the peripheral has been serviced.

Top module: `l2irq_aggregator`

## Requirements
- R1: After reset every enable bit reads as disabled (mask view 0xFFFFFFFF), every latched pending bit reads 0, the request output is 0, and the read data is 0.
- R2: In latched mode a 0-to-1 transition of source i sets pending bit i. The bit stays set until a write to offset 0x08 carries a 1 in bit i. Zero bits in that write leave pending bits unchanged.
- R3: Writing a 1 in bit i to the mask-set offset (0x10 latched, 0x08 level) disables source i. Writing a 1 to the mask-clear offset (0x14 latched, 0x0C level) enables it. Zero bits leave the mask bit unchanged. The mask reads back at 0x0C (latched) or 0x04 (level), where a 1 means disabled.
- R4: In latched mode, when a new rising edge on a source arrives in the same cycle as an acknowledge write for that bit, the pending bit ends up set.
- R5: Pending bits are recorded whether or not the source is disabled.
- R6: The request output equals the OR over all bits of (pending AND NOT mask), as those registers stood at the previous clock edge.
- R7: In level mode, reading offset 0x00 returns the source inputs as sampled at the read's clock edge, and there is no acknowledge register.
- R8: Reads of any offset other than the pending and mask views return 0. Writes to the pending-view or mask-view offsets, or to unmapped offsets, change nothing.
- R9: Read data appears in the cycle after the read strobe is sampled, and is 0 in any cycle that follows no read.
- R10: A mask-set write of bit i followed by an acknowledge write of bit i leaves source i disabled and its pending bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | NUM_SRC | Source interrupt inputs, synchronous to clk |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Registered read data |
| irq_out | output | 1 | Registered request to the parent controller |

## Verification
A corrupted pending or mask bit shows up in the read data at the very next read of that view. If the bit belongs to an enabled source, it also shows on irq_out one clock after the corruption, as a request that is missing or should not be there. A lost edge, for example one dropped while an acknowledge write lands, shows up as a pending bit that reads as 0 when it should read as 1. A mask change at the wrong offset shows up as a wrong mask-view word, and also as a request edge that comes one cycle early or not at all.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

  typedef enum logic [0:0] {
    MODE_LEVEL   = 1'b0,
    MODE_LATCHED = 1'b1
  } irq_mode_e;

  // decoded write targets
  typedef struct packed {
    logic ack;
    logic mask_on;
    logic mask_off;
  } wr_sel_t;

  // decoded read targets
  typedef struct packed {
    logic pend;
    logic mask_view;
  } rd_sel_t;

  localparam int unsigned OFS_PEND = 32'h00;
  localparam int unsigned OFS_ACK  = 32'h08;

  function automatic int unsigned ofs_mask_view(irq_mode_e m);
    return (m == MODE_LATCHED) ? 32'h0C : 32'h04;
  endfunction

  function automatic int unsigned ofs_mask_on(irq_mode_e m);
    return (m == MODE_LATCHED) ? 32'h10 : 32'h08;
  endfunction

  function automatic int unsigned ofs_mask_off(irq_mode_e m);
    return (m == MODE_LATCHED) ? 32'h14 : 32'h0C;
  endfunction

endpackage

// File: rtl/l2irq_rst_sync.sv
module l2irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/l2irq_decode.sv
module l2irq_decode
  import l2irq_pkg::*;
#(
  parameter irq_mode_e   MODE   = MODE_LATCHED,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output wr_sel_t           wsel,
  output rd_sel_t           rsel
);

  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_MV   = ADDR_W'(ofs_mask_view(MODE));
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(ofs_mask_on(MODE));
  localparam logic [ADDR_W-1:0] A_MOFF = ADDR_W'(ofs_mask_off(MODE));
  localparam logic              HAS_ACK = (MODE == MODE_LATCHED);

  always_comb begin
    wsel          = '0;
    rsel          = '0;
    wsel.ack      = HAS_ACK && wr && (addr == A_ACK);
    wsel.mask_on  = wr && (addr == A_MON);
    wsel.mask_off = wr && (addr == A_MOFF);
    rsel.pend     = rd && (addr == A_PEND);
    rsel.mask_view = rd && (addr == A_MV);
  end

endmodule

// File: rtl/l2irq_pending.sv
module l2irq_pending
  import l2irq_pkg::*;
#(
  parameter irq_mode_e   MODE    = MODE_LATCHED,
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               ack_en,
  input  logic [NUM_SRC-1:0] ack_bits,
  output logic [NUM_SRC-1:0] pend
);

  if (MODE == MODE_LATCHED) begin : g_latched
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_nxt;
    logic [NUM_SRC-1:0] rise;
    logic               pend_upd;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      assign rise[i]     = src[i] & ~src_q[i];
      // a new edge outranks an acknowledge in the same cycle
      assign pend_nxt[i] = rise[i] | (pend_q[i] & ~(ack_en & ack_bits[i]));
    end

    assign pend_upd = ack_en | (|rise);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q  <= '0;
        pend_q <= '0;
      end else begin
        src_q <= src;
        if (pend_upd) pend_q <= pend_nxt;
      end
    end

    assign pend = pend_q;
  end else begin : g_level
    assign pend = src;
  end

endmodule

// File: rtl/l2irq_mask.sv
module l2irq_mask #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               on_en,
  input  logic               off_en,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask
);

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_nxt;
  logic               mask_upd;

  always_comb begin
    mask_nxt = mask_q;
    if (on_en)  mask_nxt = mask_nxt | wdata;
    if (off_en) mask_nxt = mask_nxt & ~wdata;
  end

  assign mask_upd = on_en | off_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '1;
    else if (mask_upd) mask_q <= mask_nxt;
  end

  assign mask = mask_q;

endmodule

// File: rtl/l2irq_aggregator.sv
module l2irq_aggregator
  import l2irq_pkg::*;
#(
  parameter irq_mode_e   MODE    = MODE_LATCHED,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_out
);

  logic               rst_sync_n;
  wr_sel_t            wsel;
  rd_sel_t            rsel;
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] mask_vec;
  logic [NUM_SRC-1:0] rdata_nxt;
  logic [NUM_SRC-1:0] rdata_q;
  logic               irq_nxt;
  logic               irq_q;

  l2irq_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  l2irq_decode #(.MODE(MODE), .ADDR_W(ADDR_W)) i_decode (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .wsel (wsel),
    .rsel (rsel)
  );

  l2irq_pending #(.MODE(MODE), .NUM_SRC(NUM_SRC)) i_pending (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .src      (src_in),
    .ack_en   (wsel.ack),
    .ack_bits (bus_wdata),
    .pend     (pend_vec)
  );

  l2irq_mask #(.NUM_SRC(NUM_SRC)) i_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .on_en  (wsel.mask_on),
    .off_en (wsel.mask_off),
    .wdata  (bus_wdata),
    .mask   (mask_vec)
  );

  always_comb begin
    rdata_nxt = '0;
    if (rsel.pend)      rdata_nxt = pend_vec;
    if (rsel.mask_view) rdata_nxt = mask_vec;
  end

  assign irq_nxt = |(pend_vec & ~mask_vec);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_nxt;
      irq_q   <= irq_nxt;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

endmodule

// File: rtl/l2irq_checker.sv
module l2irq_checker
  import l2irq_pkg::*;
#(
  parameter irq_mode_e   MODE    = MODE_LATCHED,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_SRC-1:0] wdata,
  input logic [NUM_SRC-1:0] src,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] mask,
  input logic               irq
);

  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(ofs_mask_on(MODE));
  localparam logic [ADDR_W-1:0] A_MOFF = ADDR_W'(ofs_mask_off(MODE));

  logic               hit_on;
  logic               hit_off;
  logic [NUM_SRC-1:0] ack_seen;

  assign hit_on   = wr && (addr == A_MON);
  assign hit_off  = wr && (addr == A_MOFF);
  assign ack_seen = (MODE == MODE_LATCHED && wr && addr == A_ACK) ? wdata : '0;

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(pend) & ~$past(mask)))); // R6

  AST_MASK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    hit_on |=> ((mask & $past(wdata)) == $past(wdata))); // R3

  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hit_off |=> ((mask & $past(wdata)) == '0)); // R3

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_on || hit_off) |=> $stable(mask)); // R8

  if (MODE == MODE_LATCHED) begin : g_latched_chk
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend) & ~pend) & ~$past(ack_seen)) == '0)); // R2

    AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & $past(src) & ~$past(src, 2)) == ($past(src) & ~$past(src, 2)))); // R4
  end

endmodule

bind l2irq_aggregator l2irq_checker #(
  .MODE(MODE), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)
) i_l2irq_checker (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .wr    (bus_wr),
  .addr  (bus_addr),
  .wdata (bus_wdata),
  .src   (src_in),
  .pend  (pend_vec),
  .mask  (mask_vec),
  .irq   (irq_out)
);

// File: tb/test_l2irq_aggregator.sv
module test_l2irq_aggregator;
  import l2irq_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [31:0] src;
  logic        wr_lat;
  logic        wr_lvl;
  logic        rd;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata_lat;
  logic [31:0] rdata_lvl;
  logic        irq_lat;
  logic        irq_lvl;

  int vectors;
  int miscompares;

  // bench model state
  logic [31:0] m_pend;
  logic [31:0] m_mask_lat;
  logic [31:0] m_mask_lvl;
  logic [31:0] m_src_prev;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  l2irq_aggregator #(.MODE(MODE_LATCHED), .NUM_SRC(32), .ADDR_W(8)) i_l2irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_wr(wr_lat), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_lat), .irq_out(irq_lat)
  );

  l2irq_aggregator #(.MODE(MODE_LEVEL), .NUM_SRC(32), .ADDR_W(8)) i_l2irq_aggregator_lvl (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_wr(wr_lvl), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_lvl), .irq_out(irq_lvl)
  );

  function automatic logic [31:0] exp_read_lat(logic [7:0] a);
    case (a)
      8'h00:   return m_pend;
      8'h0C:   return m_mask_lat;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read_lvl(logic [7:0] a, logic [31:0] s);
    case (a)
      8'h00:   return s;
      8'h04:   return m_mask_lvl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one bus cycle: drive at a falling edge, compare at the next falling edge
  task automatic step(input logic [31:0] s, input logic wl, input logic wv,
                      input logic r, input logic [7:0] a, input logic [31:0] d,
                      input string tag);
    logic [31:0] e_rd_lat, e_rd_lvl, clr, rise;
    logic        e_irq_lat, e_irq_lvl;
    src = s; wr_lat = wl; wr_lvl = wv; rd = r; addr = a; wdata = d;
    e_rd_lat  = r ? exp_read_lat(a) : 32'h0;
    e_rd_lvl  = r ? exp_read_lvl(a, s) : 32'h0;
    e_irq_lat = |(m_pend & ~m_mask_lat);
    e_irq_lvl = |(s & ~m_mask_lvl);
    rise = s & ~m_src_prev;
    clr  = (wl && a == 8'h08) ? d : 32'h0;
    m_pend = (m_pend & ~clr) | rise;
    if (wl && a == 8'h10) m_mask_lat = m_mask_lat | d;
    if (wl && a == 8'h14) m_mask_lat = m_mask_lat & ~d;
    if (wv && a == 8'h08) m_mask_lvl = m_mask_lvl | d;
    if (wv && a == 8'h0C) m_mask_lvl = m_mask_lvl & ~d;
    m_src_prev = s;
    @(negedge clk);
    chk({tag, " R9 rdata latched"}, rdata_lat, e_rd_lat);
    chk({tag, " R9 rdata level"}, rdata_lvl, e_rd_lvl);
    chk({tag, " R6 irq latched"}, {31'h0, irq_lat}, {31'h0, e_irq_lat});
    chk({tag, " R6 irq level"}, {31'h0, irq_lvl}, {31'h0, e_irq_lvl});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [7:0]  offs [7];
    vectors = 0; miscompares = 0;
    offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18};
    rst_n = 1'b0; src = '0; wr_lat = 0; wr_lvl = 0; rd = 0; addr = '0; wdata = '0;
    m_pend = '0; m_mask_lat = '1; m_mask_lvl = '1; m_src_prev = '0;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    chk("R1 irq latched", {31'h0, irq_lat}, 32'h0);
    chk("R1 irq level", {31'h0, irq_lvl}, 32'h0);
    chk("R1 rdata idle", rdata_lat, 32'h0);
    step('0, 0, 0, 1, 8'h00, '0, "R1 pending view");
    step('0, 0, 0, 1, 8'h0C, '0, "R1 latched mask view");
    step('0, 0, 0, 1, 8'h04, '0, "R1 level mask view");

    // R5 edge recorded while masked
    step(32'h8, 0, 0, 0, 8'h00, '0, "R5 rise bit3");
    step(32'h8, 0, 0, 1, 8'h00, '0, "R5 pending while masked");
    // R3 enable bit3 in both variants
    step(32'h8, 1, 0, 0, 8'h14, 32'h8, "R3 latched enable");
    step(32'h8, 0, 1, 0, 8'h0C, 32'h8, "R3 level enable");
    step(32'h8, 0, 0, 1, 8'h0C, '0, "R3 latched mask view");
    step(32'h8, 0, 0, 1, 8'h04, '0, "R3 level mask view");
    // R7 level status follows inputs
    step(32'h0, 0, 0, 1, 8'h00, '0, "R7 level drops");
    // R10 mask then acknowledge
    step(32'h0, 1, 0, 0, 8'h10, 32'h8, "R10 mask");
    step(32'h0, 1, 0, 0, 8'h08, 32'h8, "R10 ack");
    step(32'h0, 0, 0, 1, 8'h00, '0, "R10 pending cleared");
    step(32'h0, 0, 0, 1, 8'h0C, '0, "R10 still masked");
    // R2 zero bits in ack leave others, R4 edge beats ack
    step(32'h20, 0, 0, 0, 8'h00, '0, "R2 rise bit5");
    step(32'h00, 1, 0, 0, 8'h08, 32'h1, "R2 ack other bit");
    step(32'h00, 0, 0, 1, 8'h00, '0, "R2 bit5 held");
    step(32'h20, 1, 0, 0, 8'h08, 32'h20, "R4 edge with ack");
    step(32'h20, 0, 0, 1, 8'h00, '0, "R4 bit5 survives");
    // R8 dead writes and unmapped reads
    step(32'h20, 1, 1, 0, 8'h00, 32'hFFFF_FFFF, "R8 write pending view");
    step(32'h20, 1, 0, 0, 8'h0C, 32'h0, "R8 write latched mask view");
    step(32'h20, 0, 1, 0, 8'h04, 32'h0, "R8 write level mask view");
    step(32'h20, 0, 1, 0, 8'h10, 32'hFFFF_FFFF, "R8 level unmapped write");
    step(32'h20, 0, 0, 1, 8'h18, '0, "R8 unmapped read");
    step(32'h20, 0, 0, 1, 8'h08, '0, "R8 ack reads zero");
    step(32'h20, 0, 0, 1, 8'h0C, '0, "R8 latched mask intact");
    step(32'h20, 0, 0, 1, 8'h04, '0, "R8 level mask intact");
    step(32'h20, 0, 0, 1, 8'h00, '0, "R8 pending intact");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      s  = m_src_prev ^ ($urandom & $urandom & $urandom);
      op = int'($urandom % 4);
      case (op)
        0: step(s, 1, 0, 0, offs[$urandom % 7], $urandom, "R2 random latched write");
        1: step(s, 0, 1, 0, offs[$urandom % 7], $urandom, "R3 random level write");
        2: step(s, 0, 0, 1, offs[$urandom % 7], '0, "R7 random read");
        default: step(s, 0, 0, 0, 8'h00, '0, "R6 random idle");
      endcase
    end

    wr_lat = 0; wr_lvl = 0; rd = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule